// File: doc/BRIEF.md
# Video Luma Undershoot Limiter

This block sits in a component-video pixel path and clamps the luma sample to a floor below black level during active video. Software-facing programming is outside the block. It takes a 2-bit limit code, and the code selects one of three sub-black levels. Parameters give the 10-bit code for each level. With 0 IRE at code 240 and 7 codes per IRE, the defaults are 229 for -1.5 IRE, 198 for -6 IRE and 163 for -11 IRE.

The floor applies only when two conditions hold: the sample lies inside active video, and the upstream interpolator reports that it is enabled. Any other sample leaves unchanged. The block does no filtering of its own. Chroma, the active flag and both sync flags pass through the same single register stage as the luma, so all outputs stay aligned.

The limit code is captured at the start of each line, which is the first sample on which the active flag is high. Limiting therefore never changes partway through a line.

Top module: `lumaUndershootLimiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: Every output is the corresponding input registered once. A value presented before a rising clock edge appears on the outputs after that edge, and the luma, both chroma samples, the active flag and both sync flags stay aligned.
- R3: Limit code 00 disables limiting, so luma passes through unchanged.
- R4: Limit code 01 selects floor code 163 (-11 IRE), code 10 selects 198 (-6 IRE) and code 11 selects 229 (-1.5 IRE).
- R5: When limiting applies, a luma sample below the selected floor is replaced by the floor code. A sample at or above the floor is unchanged.
- R6: A sample with the active flag low passes through unchanged, whatever the limit code.
- R7: A sample with the interpolation-enable flag low passes through unchanged.
- R8: The limit code is sampled on the first active sample of a line, where the active flag rises. That sample already uses the new code, and any change to the code later in the same line has no effect until the next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lumaIn | input | 10 | Input luma sample |
| cbIn | input | 10 | Input blue-difference chroma |
| crIn | input | 10 | Input red-difference chroma |
| activeIn | input | 1 | High during active video |
| hsyncIn | input | 1 | Horizontal sync flag |
| vsyncIn | input | 1 | Vertical sync flag |
| interpEnIn | input | 1 | Upstream interpolation enabled |
| limitSelIn | input | 2 | Limit code: 00 off, 01 -11 IRE, 10 -6 IRE, 11 -1.5 IRE |
| lumaOut | output | 10 | Limited luma, one cycle later |
| cbOut | output | 10 | Delayed blue-difference chroma |
| crOut | output | 10 | Delayed red-difference chroma |
| activeOut | output | 1 | Delayed active flag |
| hsyncOut | output | 1 | Delayed horizontal sync |
| vsyncOut | output | 1 | Delayed vertical sync |

## Verification
Two functions can fall in the same cycle: capturing a new limit code at a line start, and clamping the sample that opens that line. The bench raises the active flag and changes the code on the same edge, with a luma value below the new floor. The result must show the new floor, not the old one. A later mid-line change to the code is then shown to leave the floor untouched until the active flag rises again.

// File: rtl/lul_pkg.sv
package lul_pkg;
  typedef enum logic [1:0] {
    LIM_OFF  = 2'b00,
    LIM_M11  = 2'b01,
    LIM_M6   = 2'b10,
    LIM_M1P5 = 2'b11
  } limSel_e;

  typedef struct packed {
    logic    clampEn;
    limSel_e selCode;
  } limStrobe_t;
endpackage

// File: rtl/lul_ctrl.sv
module lul_ctrl
  import lul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       activeIn,
  input  logic       interpEnIn,
  input  logic [1:0] limitSelIn,
  output limStrobe_t strobes
);
  logic    prevActive;
  limSel_e heldSel;
  limSel_e effSel;
  logic    lineStart;

  assign lineStart = activeIn && !prevActive;

  always_comb begin
    effSel = lineStart ? limSel_e'(limitSelIn) : heldSel;
    strobes.selCode = effSel;
    strobes.clampEn = activeIn && interpEnIn && (effSel != LIM_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      heldSel    <= LIM_OFF;
    end else begin
      prevActive <= activeIn;
      if (lineStart) heldSel <= limSel_e'(limitSelIn);
    end
  end

  // R8: the code in force stays fixed for the rest of a line
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (activeIn && prevActive) |=> (!activeIn || !$past(activeIn) || effSel == $past(effSel)));
endmodule

// File: rtl/lul_datapath.sv
module lul_datapath
  import lul_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int FLOOR_M11  = 163,
  parameter int FLOOR_M6   = 198,
  parameter int FLOOR_M1P5 = 229
) (
  input  logic              clk,
  input  logic              rstN,
  input  limStrobe_t        strobes,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic [DATA_W-1:0] cbIn,
  input  logic [DATA_W-1:0] crIn,
  input  logic              activeIn,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  output logic [DATA_W-1:0] lumaOut,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] crOut,
  output logic              activeOut,
  output logic              hsyncOut,
  output logic              vsyncOut
);
  localparam logic [DATA_W-1:0] F11 = DATA_W'(FLOOR_M11);
  localparam logic [DATA_W-1:0] F6  = DATA_W'(FLOOR_M6);
  localparam logic [DATA_W-1:0] F15 = DATA_W'(FLOOR_M1P5);

  logic [DATA_W-1:0] floorCode;
  logic [DATA_W-1:0] lumaNext;
  logic              belowFloor;

  always_comb begin
    case (strobes.selCode)
      LIM_M11:  floorCode = F11;
      LIM_M6:   floorCode = F6;
      LIM_M1P5: floorCode = F15;
      default:  floorCode = '0;
    endcase
    belowFloor = lumaIn < floorCode;
    lumaNext   = (strobes.clampEn && belowFloor) ? floorCode : lumaIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lumaOut   <= '0;
      cbOut     <= '0;
      crOut     <= '0;
      activeOut <= 1'b0;
      hsyncOut  <= 1'b0;
      vsyncOut  <= 1'b0;
    end else begin
      lumaOut   <= lumaNext;
      cbOut     <= cbIn;
      crOut     <= crIn;
      activeOut <= activeIn;
      hsyncOut  <= hsyncIn;
      vsyncOut  <= vsyncIn;
    end
  end

  // R5: a clamped sample never leaves below the floor in force
  p_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clampEn |=> lumaOut >= $past(floorCode));

  // R6, R7: without the clamp strobe the luma is passed on as it came
  p_passthru_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clampEn |=> lumaOut == $past(lumaIn));

  // R2: the active flag and the luma leave in the same cycle
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> activeOut == $past(activeIn));

  // R3: code 00 never raises the clamp strobe
  p_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.selCode == LIM_OFF) |-> !strobes.clampEn);
endmodule

// File: rtl/lumaUndershootLimiter.sv
module lumaUndershootLimiter
  import lul_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int FLOOR_M11  = 163,
  parameter int FLOOR_M6   = 198,
  parameter int FLOOR_M1P5 = 229
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic [DATA_W-1:0] cbIn,
  input  logic [DATA_W-1:0] crIn,
  input  logic              activeIn,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic              interpEnIn,
  input  logic [1:0]        limitSelIn,
  output logic [DATA_W-1:0] lumaOut,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] crOut,
  output logic              activeOut,
  output logic              hsyncOut,
  output logic              vsyncOut
);
  limStrobe_t strobes;

  lul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .activeIn(activeIn), .interpEnIn(interpEnIn),
    .limitSelIn(limitSelIn), .strobes(strobes)
  );

  lul_datapath #(
    .DATA_W(DATA_W), .FLOOR_M11(FLOOR_M11), .FLOOR_M6(FLOOR_M6), .FLOOR_M1P5(FLOOR_M1P5)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lumaIn(lumaIn), .cbIn(cbIn), .crIn(crIn),
    .activeIn(activeIn), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .lumaOut(lumaOut), .cbOut(cbOut), .crOut(crOut),
    .activeOut(activeOut), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );
endmodule

// File: tb/tb_lumaUndershootLimiter.sv
module tb_lumaUndershootLimiter;
  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] lumaIn, cbIn, crIn;
  logic       activeIn, hsyncIn, vsyncIn, interpEnIn;
  logic [1:0] limitSelIn;
  logic [9:0] lumaOut, cbOut, crOut;
  logic       activeOut, hsyncOut, vsyncOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  lumaUndershootLimiter dut (
    .clk(clk), .rstN(rstN), .lumaIn(lumaIn), .cbIn(cbIn), .crIn(crIn),
    .activeIn(activeIn), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .interpEnIn(interpEnIn), .limitSelIn(limitSelIn),
    .lumaOut(lumaOut), .cbOut(cbOut), .crOut(crOut),
    .activeOut(activeOut), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );

  // {active, interp, sel[1:0], luma[9:0], expected[9:0]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b1, 2'b01, 10'd100,  10'd163},   // R4 R5
    {1'b1, 1'b1, 2'b01, 10'd163,  10'd163},   // R5 at floor
    {1'b1, 1'b1, 2'b01, 10'd162,  10'd163},   // R5 one below
    {1'b1, 1'b1, 2'b01, 10'd164,  10'd164},   // R5 above
    {1'b1, 1'b1, 2'b10, 10'd197,  10'd198},   // R4
    {1'b1, 1'b1, 2'b10, 10'd198,  10'd198},   // R5
    {1'b1, 1'b1, 2'b10, 10'd0,    10'd198},   // R5 zero
    {1'b1, 1'b1, 2'b11, 10'd228,  10'd229},   // R4
    {1'b1, 1'b1, 2'b11, 10'd229,  10'd229},   // R5
    {1'b1, 1'b1, 2'b11, 10'd500,  10'd500},   // R5
    {1'b1, 1'b1, 2'b00, 10'd10,   10'd10},    // R3
    {1'b1, 1'b0, 2'b01, 10'd50,   10'd50},    // R7
    {1'b0, 1'b1, 2'b11, 10'd50,   10'd50},    // R6
    {1'b1, 1'b1, 2'b11, 10'd1023, 10'd1023}   // R5 top code
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic act, input logic ie, input logic [1:0] sel, input logic [9:0] y);
    activeIn = act; interpEnIn = ie; limitSelIn = sel; lumaIn = y;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0;
    lumaIn = 10'd77; cbIn = 10'd300; crIn = 10'd400;
    activeIn = 1'b1; hsyncIn = 1'b1; vsyncIn = 1'b1;
    interpEnIn = 1'b1; limitSelIn = 2'b01;
    step(); step();
    // R1: reset state
    check("R1 luma", lumaOut, 10'd0);
    check("R1 cb", cbOut, 10'd0);
    check("R1 flags", {7'd0, activeOut, hsyncOut, vsyncOut}, 10'd0);
    rstN = 1'b1;
    drive(1'b0, 1'b1, 2'b00, 10'd0);
    hsyncIn = 1'b0; vsyncIn = 1'b0;
    step();

    // Table: each vector opens a fresh line after an idle sample
    for (int i = 0; i < NV; i++) begin
      drive(1'b0, 1'b0, 2'b00, 10'd0);
      step();
      drive(VEC[i][23], VEC[i][22], VEC[i][21:20], VEC[i][19:10]);
      step();
      check($sformatf("R3-R7 vector %0d", i), lumaOut, VEC[i][9:0]);
    end

    // R2: alignment and one-cycle latency
    drive(1'b0, 1'b0, 2'b00, 10'd0);
    step();
    @(negedge clk);
    lumaIn = 10'd600; cbIn = 10'd111; crIn = 10'd222;
    activeIn = 1'b1; hsyncIn = 1'b1; vsyncIn = 1'b0;
    #1;
    check("R2 no early luma", lumaOut, 10'd0);
    step();
    check("R2 luma", lumaOut, 10'd600);
    check("R2 cb", cbOut, 10'd111);
    check("R2 cr", crOut, 10'd222);
    check("R2 flags", {7'd0, activeOut, hsyncOut, vsyncOut}, 10'b110);
    hsyncIn = 1'b0; vsyncIn = 1'b1;
    step();
    check("R2 vsync", {9'd0, vsyncOut}, 10'd1);

    // R8: code captured at line start, mid-line change ignored
    drive(1'b0, 1'b1, 2'b11, 10'd0);
    step();
    drive(1'b1, 1'b1, 2'b01, 10'd100);
    step();
    check("R8 new code at line start", lumaOut, 10'd163);
    drive(1'b1, 1'b1, 2'b11, 10'd200);
    step();
    check("R8 mid-line change ignored", lumaOut, 10'd200);
    drive(1'b1, 1'b1, 2'b00, 10'd100);
    step();
    check("R8 mid-line off ignored", lumaOut, 10'd163);
    drive(1'b0, 1'b1, 2'b11, 10'd100);
    step();
    check("R6 blanking", lumaOut, 10'd100);
    drive(1'b1, 1'b1, 2'b11, 10'd200);
    step();
    check("R8 next line start", lumaOut, 10'd229);
    drive(1'b1, 1'b0, 2'b11, 10'd200);
    step();
    check("R7 interp off mid-line", lumaOut, 10'd200);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule